// File: doc/BRIEF.md
# Split-Half Host Access Port

This block is the host side of a wide storage engine. Entries in the memory and in the register file are 128 bits wide. The host data bus is 64 bits wide, so the host reaches each entry one half at a time. A half-select input picks the upper or the lower 64 bits. Four active-low lane enables then open or close 16-bit slices inside that half. Memory is addressed by an internal 10-bit pointer. The host can load the pointer, read it back, and have it advance by one after every memory access. Memory writes can be filtered bit by bit through one of two mask registers.

A small two-state controller tracks chip select.

- In `ST_OFF` the port ignores all traffic and drives its data output as zero with the output-enable low.
- The first selected cycle is the `OFF->ON` transition, also called the activation cycle. In that cycle only comparand-register reads and writes take effect. Any other operation is dropped, which works as an implicit no-op.
- From then on the port stays in `ST_ON` (`ON->ON`) while chip select is held.
- A deselected cycle moves it back to `ST_OFF` (`ON->OFF`). It stays there (`OFF->OFF`) until chip select returns.
- Reset forces `ST_OFF`, so the first selected cycle after reset is also an activation cycle.

Top module: `hwap_access_port`

## Requirements
- R1: An active-low asynchronous reset clears all four registers and the address pointer to zero. It also leaves `dout_oe` low and `dout` at zero until the next selected cycle.
- R2: Register operations address registers by index: comparand 0, mask A 1, mask B 2, configuration 3. Code 8+index reads a register and code 12+index writes it. With `sel_upper` high, bits 127:64 are accessed; with it low, bits 63:0 are accessed. The other half is never changed.
- R3: Within the chosen half, `wen_n[k]` low enables bits 16k+15 down to 16k. For example, `wen_n[3]` covers bits 63:48 of the half.
- R4: A write leaves the bits of disabled lanes unchanged. A read returns zeros in the lanes of disabled lanes.
- R5: Memory operation codes:
  - Code 1 reads the entry at the pointer.
  - Code 2 writes the entry with no mask.
  - Code 3 writes the entry with mask A; every bit that is 1 in mask A keeps its old value.
  - Code 4 writes the entry with mask B, in the same way.
- R6: Code 5 loads the pointer from `din[9:0]`. Code 6 returns the pointer on `dout[9:0]` with all upper bits zero. Both codes ignore `wen_n` and `sel_upper`.
- R7: When configuration bit 0 is 1, the pointer advances by one after each accepted memory read or write. When that bit is 0, the pointer holds. Codes other than 1 to 5 never move the pointer.
- R8: Advancing from 1023 gives 0.
- R9: In the activation cycle (chip select low after a deselected cycle or after reset), only codes 8 and 12 take effect. Every other code has no effect on state or on `dout`.
- R10: A cycle with `ce_n` high has no effect on state. In the following cycle `dout_oe` is low and `dout` is zero. A cycle with `ce_n` low gives `dout_oe` high in the following cycle.
- R11: Read data appears on `dout` in the cycle after the read is presented. It holds until the next accepted read.
- R12: Codes 0 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip select, active low |
| op_code | input | 4 | Operation code |
| sel_upper | input | 1 | 1 = upper 64-bit half, 0 = lower half |
| wen_n | input | 4 | Active-low 16-bit lane enables |
| din | input | 64 | Write data / pointer load value |
| dout | output | 64 | Read data, zero when not enabled |
| dout_oe | output | 1 | Output enable for `dout` |

## Verification
The bench sweeps all sixteen lane patterns in both halves. After each write it reads the word back three ways: through every lane, through the same partial lanes, and through the opposite half. A design with a swapped lane map or a swapped half decode would corrupt bits that ought to survive. A design that leaked stale lanes on reads would return non-zero slices.

Masked memory writes rotate through no mask, mask A and mask B with irregular lane patterns. Pointer tests walk across the 1023-to-0 wrap with auto-advance on and off. A pointer that failed to wrap, or that advanced on a load, would read the wrong entry.

Activation cycles are issued with a register write, a memory read and comparand accesses. A controller that skipped the implicit no-op would accept the first write. One that blocked the comparand would drop it.

// File: rtl/hwap_pkg.sv
`timescale 1ns/1ps
// Shared encodings of the split-half host access port.
package hwap_pkg;

    // Operation codes presented on op_code.
    typedef enum logic [3:0] {
        OP_NOP       = 4'd0,
        OP_RD_MEM    = 4'd1,
        OP_WR_MEM    = 4'd2,
        OP_WR_MEM_MA = 4'd3,
        OP_WR_MEM_MB = 4'd4,
        OP_LD_PTR    = 4'd5,
        OP_RD_PTR    = 4'd6,
        OP_RSVD      = 4'd7,
        OP_RD_CMP    = 4'd8,
        OP_RD_MSKA   = 4'd9,
        OP_RD_MSKB   = 4'd10,
        OP_RD_CFG    = 4'd11,
        OP_WR_CMP    = 4'd12,
        OP_WR_MSKA   = 4'd13,
        OP_WR_MSKB   = 4'd14,
        OP_WR_CFG    = 4'd15
    } op_e;

    // Chip-select tracking states.
    typedef enum logic {
        ST_OFF = 1'b0,
        ST_ON  = 1'b1
    } port_st_e;

    // Write-mask choice for memory writes.
    typedef enum logic [1:0] {
        MSK_NONE = 2'd0,
        MSK_A    = 2'd1,
        MSK_B    = 2'd2
    } msk_e;

    // Register file slots.
    localparam int NUM_REGS = 4;
    localparam int REG_CMP  = 0;
    localparam int REG_MSKA = 1;
    localparam int REG_MSKB = 2;
    localparam int REG_CFG  = 3;

endpackage

// File: rtl/hwap_lane_steer.sv
`timescale 1ns/1ps
// Half and lane steering: builds per-bit write enables for the selected
// half and gates the read half by the active lanes.
module hwap_lane_steer #(
    parameter int BUS_W  = 64,
    parameter int LANE_W = 16,
    localparam int LANES  = BUS_W / LANE_W,
    localparam int WORD_W = 2 * BUS_W
) (
    input  logic              sel_upper,
    input  logic [LANES-1:0]  wen_n,
    input  logic [BUS_W-1:0]  din,
    input  logic [WORD_W-1:0] rd_word,
    output logic [WORD_W-1:0] bit_en,
    output logic [WORD_W-1:0] wr_word,
    output logic [BUS_W-1:0]  rd_half
);

    logic [BUS_W-1:0] lane_bits;
    logic [BUS_W-1:0] half_pick;

    // One enable slice per lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bits[g*LANE_W +: LANE_W] = {LANE_W{~wen_n[g]}};
    end

    // Write side: enables land in the chosen half only.
    assign bit_en  = sel_upper ? {lane_bits, {BUS_W{1'b0}}}
                               : {{BUS_W{1'b0}}, lane_bits};
    assign wr_word = {din, din};

    // Read side: pick the half, then blank closed lanes.
    assign half_pick = sel_upper ? rd_word[WORD_W-1:BUS_W] : rd_word[BUS_W-1:0];
    assign rd_half   = half_pick & lane_bits;

endmodule

// File: rtl/hwap_addr_ctr.sv
`timescale 1ns/1ps
// Memory address pointer: load, or advance by one with natural wrap.
module hwap_addr_ctr #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_val;
        end else if (step) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/hwap_regfile.sv
`timescale 1ns/1ps
// Register file: NUM_REGS words of WORD_W bits, per-bit write enables,
// cleared by reset. All words are exposed as one flat vector.
module hwap_regfile
    import hwap_pkg::*;
#(
    parameter int WORD_W = 128,
    localparam int SEL_W  = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [SEL_W-1:0]           wr_sel,
    input  logic [WORD_W-1:0]          bit_en,
    input  logic [WORD_W-1:0]          wr_word,
    output logic [NUM_REGS*WORD_W-1:0] regs
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [WORD_W-1:0] val_q;
        logic              hit;

        assign hit = wr_en && (wr_sel == SEL_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= '0;
            end else if (hit) begin
                val_q <= (val_q & ~bit_en) | (wr_word & bit_en);
            end
        end

        assign regs[g*WORD_W +: WORD_W] = val_q;
    end

endmodule

// File: rtl/hwap_mem.sv
`timescale 1ns/1ps
// Storage array with per-bit write enables and combinational read.
module hwap_mem #(
    parameter int WORD_W = 128,
    parameter int ADDR_W = 10,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] bit_en,
    input  logic [WORD_W-1:0] wr_word,
    output logic [WORD_W-1:0] rd_word
);

    logic [WORD_W-1:0] arr [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            arr[addr] <= (arr[addr] & ~bit_en) | (wr_word & bit_en);
        end
    end

    assign rd_word = arr[addr];

endmodule

// File: rtl/hwap_access_port.sv
`timescale 1ns/1ps
// Split-half host access port: chip-select state machine, operation
// decode, half/lane steering, masked memory writes, address pointer.
module hwap_access_port
    import hwap_pkg::*;
#(
    parameter int BUS_W  = 64,
    parameter int LANE_W = 16,
    parameter int ADDR_W = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ce_n,
    input  logic [3:0]                op_code,
    input  logic                      sel_upper,
    input  logic [BUS_W/LANE_W-1:0]   wen_n,
    input  logic [BUS_W-1:0]          din,
    output logic [BUS_W-1:0]          dout,
    output logic                      dout_oe
);

    localparam int WORD_W = 2 * BUS_W;
    localparam int LANES  = BUS_W / LANE_W;
    localparam int SEL_W  = $clog2(NUM_REGS);

    // ---------------- state machine ----------------
    port_st_e state_q, state_d;
    op_e      op;
    logic     is_cmp_op;
    logic     accept;
    logic     st_off;

    assign op        = op_e'(op_code);
    assign is_cmp_op = (op == OP_RD_CMP) || (op == OP_WR_CMP);
    assign st_off    = (state_q == ST_OFF);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions and acceptance.
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                if (!ce_n) begin
                    // OFF->ON: activation cycle, comparand access only
                    state_d = ST_ON;
                    accept  = is_cmp_op;
                end
            end
            ST_ON: begin
                if (ce_n) begin
                    state_d = ST_OFF;   // ON->OFF
                end else begin
                    accept  = 1'b1;     // ON->ON
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // ---------------- operation decode (outputs) ----------------
    logic mem_rd, mem_wr, ptr_ld, ptr_rd, reg_rd, reg_wr;
    msk_e msk;

    always_comb begin
        mem_rd = 1'b0;
        mem_wr = 1'b0;
        ptr_ld = 1'b0;
        ptr_rd = 1'b0;
        reg_rd = 1'b0;
        reg_wr = 1'b0;
        msk    = MSK_NONE;
        if (accept) begin
            unique case (op)
                OP_NOP, OP_RSVD: ;
                OP_RD_MEM:    mem_rd = 1'b1;
                OP_WR_MEM:    mem_wr = 1'b1;
                OP_WR_MEM_MA: begin mem_wr = 1'b1; msk = MSK_A; end
                OP_WR_MEM_MB: begin mem_wr = 1'b1; msk = MSK_B; end
                OP_LD_PTR:    ptr_ld = 1'b1;
                OP_RD_PTR:    ptr_rd = 1'b1;
                OP_RD_CMP, OP_RD_MSKA, OP_RD_MSKB, OP_RD_CFG: reg_rd = 1'b1;
                OP_WR_CMP, OP_WR_MSKA, OP_WR_MSKB, OP_WR_CFG: reg_wr = 1'b1;
            endcase
        end
    end

    logic mem_fire;
    logic rd_lane_fire;
    assign mem_fire     = mem_rd | mem_wr;
    assign rd_lane_fire = mem_rd | reg_rd;

    // ---------------- steering ----------------
    logic [WORD_W-1:0] bit_en, wr_word, rd_word, mem_rd_word, reg_rd_word;
    logic [BUS_W-1:0]  rd_half;

    hwap_lane_steer #(
        .BUS_W  (BUS_W),
        .LANE_W (LANE_W)
    ) u_steer (
        .sel_upper (sel_upper),
        .wen_n     (wen_n),
        .din       (din),
        .rd_word   (rd_word),
        .bit_en    (bit_en),
        .wr_word   (wr_word),
        .rd_half   (rd_half)
    );

    // ---------------- register file ----------------
    logic [NUM_REGS*WORD_W-1:0] regs;
    logic [SEL_W-1:0]           reg_idx;
    logic                       auto_inc;
    logic [WORD_W-1:0]          mask_a, mask_b, wr_mask;

    assign reg_idx = op_code[SEL_W-1:0];

    hwap_regfile #(
        .WORD_W (WORD_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_sel  (reg_idx),
        .bit_en  (bit_en),
        .wr_word (wr_word),
        .regs    (regs)
    );

    assign reg_rd_word = regs[reg_idx*WORD_W +: WORD_W];
    assign mask_a      = regs[REG_MSKA*WORD_W +: WORD_W];
    assign mask_b      = regs[REG_MSKB*WORD_W +: WORD_W];
    assign auto_inc    = regs[REG_CFG*WORD_W];

    always_comb begin
        unique case (msk)
            MSK_A:   wr_mask = mask_a;
            MSK_B:   wr_mask = mask_b;
            default: wr_mask = '0;
        endcase
    end

    // ---------------- address pointer ----------------
    logic [ADDR_W-1:0] ptr;

    hwap_addr_ctr #(
        .ADDR_W (ADDR_W)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_ld),
        .load_val (din[ADDR_W-1:0]),
        .step     (mem_fire & auto_inc),
        .addr     (ptr)
    );

    // ---------------- memory ----------------
    hwap_mem #(
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W)
    ) u_mem (
        .clk     (clk),
        .we      (mem_wr),
        .addr    (ptr),
        .bit_en  (bit_en & ~wr_mask),
        .wr_word (wr_word),
        .rd_word (mem_rd_word)
    );

    // Register reads carry op_code[3] set; memory reads do not.
    assign rd_word = op_code[3] ? reg_rd_word : mem_rd_word;

    // ---------------- read output ----------------
    logic [BUS_W-1:0] rd_q;
    logic             oe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
            oe_q <= 1'b0;
        end else begin
            oe_q <= ~ce_n;
            if (ptr_rd) begin
                rd_q <= {{(BUS_W-ADDR_W){1'b0}}, ptr};
            end else if (rd_lane_fire) begin
                rd_q <= rd_half;
            end
        end
    end

    assign dout    = oe_q ? rd_q : '0;
    assign dout_oe = oe_q;

endmodule

// File: rtl/hwap_port_chk.sv
`timescale 1ns/1ps
// Property checker for the split-half host access port.
module hwap_port_chk #(
    parameter int BUS_W  = 64,
    parameter int LANE_W = 16,
    parameter int ADDR_W = 10,
    localparam int LANES  = BUS_W / LANE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic [LANES-1:0]  wen_n,
    input logic [ADDR_W-1:0] ld_val,
    input logic [BUS_W-1:0]  dout,
    input logic              dout_oe,
    input logic              st_off,
    input logic              is_cmp_op,
    input logic              mem_fire,
    input logic              ptr_ld,
    input logic              rd_lane_fire,
    input logic              auto_inc,
    input logic [ADDR_W-1:0] ptr
);

    p_oe_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (!dout_oe && dout == '0));

    p_oe_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n |=> dout_oe);

    for (genvar g = 0; g < LANES; g++) begin : g_lz
        p_lane_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_lane_fire && wen_n[g]) |=> (dout[g*LANE_W +: LANE_W] == '0));
    end

    p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_fire && auto_inc && !ptr_ld) |=> (ptr == $past(ptr) + 1'b1));

    p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_fire && !ptr_ld) |=> $stable(ptr));

    p_ptr_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_ld |=> (ptr == $past(ld_val)));

    p_wake_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_off && !ce_n && !is_cmp_op) |=> $stable(ptr));

endmodule

bind hwap_access_port hwap_port_chk #(
    .BUS_W  (BUS_W),
    .LANE_W (LANE_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ce_n         (ce_n),
    .wen_n        (wen_n),
    .ld_val       (din[ADDR_W-1:0]),
    .dout         (dout),
    .dout_oe      (dout_oe),
    .st_off       (st_off),
    .is_cmp_op    (is_cmp_op),
    .mem_fire     (mem_fire),
    .ptr_ld       (ptr_ld),
    .rd_lane_fire (rd_lane_fire),
    .auto_inc     (auto_inc),
    .ptr          (ptr)
);

// File: tb/hwap_access_port_tb.sv
`timescale 1ns/1ps
module hwap_access_port_tb;

    localparam logic [3:0] C_NOP = 4'd0, C_RDM = 4'd1, C_WRM = 4'd2, C_WRMA = 4'd3,
                           C_WRMB = 4'd4, C_LDP = 4'd5, C_RDP = 4'd6, C_RSV = 4'd7,
                           C_RDR = 4'd8, C_WRR = 4'd12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        ce_n = 1'b1;
    logic [3:0]  op_code = 4'd0;
    logic        sel_upper = 1'b0;
    logic [3:0]  wen_n = 4'hF;
    logic [63:0] din = '0;
    logic [63:0] dout;
    logic        dout_oe;

    int n_chk = 0;
    int n_bad = 0;

    // Reference state derived from the requirements.
    logic [127:0] m_reg [4];
    logic [127:0] m_mem [1024];
    logic [9:0]   m_ptr;
    bit           m_on;
    bit           m_oe;
    logic [63:0]  m_rd;

    always #2.5 clk = ~clk;

    hwap_access_port u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .op_code   (op_code),
        .sel_upper (sel_upper),
        .wen_n     (wen_n),
        .din       (din),
        .dout      (dout),
        .dout_oe   (dout_oe)
    );

    task automatic chk(input string tag, input logic [64:0] act, input logic [64:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got oe/data %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] lane_mask(input logic [3:0] wn);
        logic [63:0] m;
        for (int k = 0; k < 4; k++) m[k*16 +: 16] = wn[k] ? 16'h0000 : 16'hFFFF;
        return m;
    endfunction

    function automatic logic [63:0] pat(input logic [9:0] a, input bit h);
        return 64'hC3A5_1E2D_0000_0000 ^ (64'(a) * 64'h0001_0003_0007_000F)
               ^ (h ? 64'hFFFF_0000_FFFF_0000 : 64'h0);
    endfunction

    // Drive one cycle (entered at a negedge), update the reference, check.
    task automatic step(input bit ce, input logic [3:0] op, input bit sel,
                        input logic [3:0] wn, input logic [63:0] d, input string tag);
        logic [63:0]  lm;
        logic [127:0] be;
        logic [127:0] msk;
        logic [127:0] w;
        bit           acc;
        lm = lane_mask(wn);
        be = sel ? {lm, 64'h0} : {64'h0, lm};
        ce_n = !ce; op_code = op; sel_upper = sel; wen_n = wn; din = d;
        acc = ce && (m_on || op == C_RDR || op == C_WRR);
        if (acc) begin
            case (op)
                C_RDM: begin
                    w = m_mem[m_ptr];
                    m_rd = (sel ? w[127:64] : w[63:0]) & lm;
                    if (m_reg[3][0]) m_ptr = m_ptr + 10'd1;
                end
                C_WRM, C_WRMA, C_WRMB: begin
                    msk = (op == C_WRMA) ? m_reg[1] : (op == C_WRMB) ? m_reg[2] : 128'h0;
                    be = be & ~msk;
                    m_mem[m_ptr] = (m_mem[m_ptr] & ~be) | ({d, d} & be);
                    if (m_reg[3][0]) m_ptr = m_ptr + 10'd1;
                end
                C_LDP: m_ptr = d[9:0];
                C_RDP: m_rd = {54'h0, m_ptr};
                default: begin
                    if (op >= C_WRR) begin
                        m_reg[op-C_WRR] = (m_reg[op-C_WRR] & ~be) | ({d, d} & be);
                    end else if (op >= C_RDR) begin
                        w = m_reg[op-C_RDR];
                        m_rd = (sel ? w[127:64] : w[63:0]) & lm;
                    end
                end
            endcase
        end
        m_on = ce;
        m_oe = ce;
        @(negedge clk);
        chk(tag, {dout_oe, dout}, {m_oe, m_oe ? m_rd : 64'h0});
    endtask

    initial begin
        for (int i = 0; i < 4; i++) m_reg[i] = '0;
        m_ptr = '0; m_on = 0; m_oe = 0; m_rd = '0;
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1", {dout_oe, dout}, 65'h0);

        // R9: activation cycle drops a mask write; R1: registers read zero.
        step(1, C_WRR + 4'd1, 0, 4'h0, '1, "R9");
        step(1, C_RDR + 4'd1, 0, 4'h0, '0, "R9");
        for (int r = 0; r < 4; r++)
            for (int h = 0; h < 2; h++)
                step(1, C_RDR + 4'(r), h[0], 4'h0, '0, "R1");

        // R10: deselected write ignored, output disabled.
        step(0, C_WRR, 0, 4'h0, '1, "R10");
        step(0, C_NOP, 0, 4'h0, '0, "R10");
        // R9: comparand write accepted in the activation cycle.
        step(1, C_WRR, 1, 4'h0, 64'hDEAD_BEEF_0BAD_F00D, "R9");
        step(1, C_RDR, 1, 4'h0, '0, "R9");
        step(1, C_NOP, 0, 4'h0, '1, "R11");
        step(1, C_RDR, 0, 4'h0, '0, "R2");

        // R2/R3/R4: full lane sweep on mask B in both halves.
        for (int s = 0; s < 2; s++) begin
            for (int w = 0; w < 16; w++) begin
                logic [63:0] d;
                d = 64'h0123_4567_89AB_CDEF + 64'(w) * 64'h1111_0101_0011_1001 + 64'(s);
                step(1, C_WRR + 4'd2, s[0], 4'(w), d, "R3");
                step(1, C_RDR + 4'd2, s[0], 4'h0, '0, "R4");
                step(1, C_RDR + 4'd2, s[0], 4'(w), '0, "R4");
                step(1, C_RDR + 4'd2, !s[0], 4'h0, '0, "R2");
            end
        end

        // R12: reserved and no-op codes change nothing.
        step(1, C_RSV, 1, 4'h0, '1, "R12");
        step(1, C_NOP, 0, 4'h0, '1, "R12");
        step(1, C_RDP, 0, 4'h0, '0, "R12");
        step(1, C_RDR + 4'd2, 1, 4'h0, '0, "R12");

        // R5/R6/R7: fill entries with the pointer held.
        for (int i = 0; i < 12; i++) begin
            logic [9:0] a;
            a = (i < 8) ? 10'(i) : 10'(1012 + i);
            step(1, C_LDP, i[0], 4'hF, {54'h2A_AAAA_AAAA_AAAA, a}, "R6");
            step(1, C_RDP, !i[0], 4'hF, '0, "R6");
            step(1, C_WRM, 0, 4'h0, pat(a, 0), "R5");
            step(1, C_WRM, 1, 4'h0, pat(a, 1), "R5");
            step(1, C_RDP, 0, 4'h0, '0, "R7");
            step(1, C_RDM, 0, 4'h0, '0, "R5");
            step(1, C_RDM, 1, 4'h0, '0, "R5");
        end

        // R5: masked writes through mask A, mask B and no mask.
        step(1, C_WRR + 4'd1, 0, 4'h0, 64'hF0F0_FF00_0F0F_00FF, "R5");
        step(1, C_WRR + 4'd1, 1, 4'h0, 64'h00FF_F0F0_FF00_0F0F, "R5");
        for (int i = 0; i < 8; i++) begin
            logic [3:0] op;
            op = (i % 3 == 0) ? C_WRM : (i % 3 == 1) ? C_WRMA : C_WRMB;
            step(1, C_LDP, 0, 4'h0, 64'(i), "R6");
            step(1, op, i[0], 4'(i * 5), ~pat(10'(i), i[0]), "R5");
            step(1, C_RDM, 0, 4'h0, '0, "R5");
            step(1, C_RDM, 1, 4'h0, '0, "R5");
            step(1, C_RDM, 1, 4'h5, '0, "R4");
        end

        // R7/R8: auto-advance across the wrap.
        step(1, C_WRR + 4'd3, 0, 4'hE, 64'h1, "R7");
        step(1, C_LDP, 0, 4'h0, 64'd1021, "R6");
        step(1, C_RDM, 0, 4'h0, '0, "R7");
        step(1, C_RDM, 1, 4'h0, '0, "R7");
        step(1, C_RDM, 0, 4'h0, '0, "R8");
        step(1, C_RDP, 0, 4'h0, '0, "R8");
        step(1, C_RDM, 1, 4'h0, '0, "R8");
        step(1, C_RDP, 0, 4'h0, '0, "R7");
        step(1, C_WRM, 0, 4'h3, 64'h5555_AAAA_5555_AAAA, "R7");
        step(1, C_RDP, 0, 4'h0, '0, "R7");
        step(1, C_WRR + 4'd3, 0, 4'hE, 64'h0, "R7");
        step(1, C_RDM, 0, 4'h0, '0, "R7");
        step(1, C_RDP, 0, 4'h0, '0, "R7");

        // R9/R10/R11: deselect, then activation with non-comparand and comparand ops.
        step(0, C_RDR, 0, 4'h0, '0, "R10");
        step(1, C_RDM, 0, 4'h0, '0, "R9");
        step(1, C_NOP, 0, 4'h0, '0, "R11");
        step(0, C_LDP, 0, 4'h0, 64'd3, "R10");
        step(1, C_LDP, 0, 4'h0, 64'd7, "R9");
        step(1, C_RDP, 0, 4'h0, '0, "R9");
        step(0, C_NOP, 0, 4'h0, '0, "R10");
        step(1, C_RDR, 1, 4'h0, '0, "R9");
        step(1, C_NOP, 1, 4'h0, '0, "R11");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule